// File: doc/BRIEF.md
# Prefetchable Read Burst Sizer with Ordered Request Queue

This block sits behind a PCI target on the on-chip side. Each request that the target has already matched to a prefetchable memory window arrives on a valid/ready port as either a posted write or a memory read. For a read, the block decodes the PCI command code and the cacheline-wrap flag. It then sets a burst length in data-path beats so that the read stops at a 32-byte-aligned address: the first such address for a plain or line read, and the second one for a read-multiple. A wrapping read always asks for a single beat. Writes always carry a single beat, together with their data and byte enables.

Reads and writes enter one in-order queue, so a read never reaches the memory-mapped bus ahead of a write that was accepted before it. The bus side presents the head of the queue on a valid/ready port. The data path width is a parameter, 32 or 64 bits. On the 64-bit variant one beat carries two DWORDs, so every count is halved. A read command code that is not one of the three prefetchable reads is consumed and dropped, and an error pulse reports it.

Top module: `pcipf_rd_sizer`

## Requirements
- R1: While reset is active and on the first cycle after it, bus_valid and rej_pulse are 0 and req_ready is 1.
- R2: A read whose req_wrap is 1 and whose command is a valid prefetchable read is issued with bus_burst = 1 on both data path widths.
- R3: A non-wrapping read with command 4'b0110 or 4'b1110 is issued with bus_burst = (32 - A) / B. Here B is the beat size in bytes (4 or 8), and A is req_addr[4:0] with its low log2(B) bits cleared. A low address byte of 0x08 gives 6 on the 32-bit path and 3 on the 64-bit path.
- R4: A non-wrapping read with command 4'b1100 is issued with bus_burst = (32 - A) / B + 32 / B, which is 9 to 16 beats (32-bit) or 5 to 8 beats (64-bit). A low address byte of 0x08 gives 14 and 7.
- R5: A read (req_write = 0) whose command is not 4'b0110, 4'b1100 or 4'b1110 is accepted when req_ready is 1. It never appears on the bus, and rej_pulse is 1 for exactly the cycle after acceptance.
- R6: A write (req_write = 1) is issued with bus_write = 1, bus_burst = 1, and its req_wdata and req_be unchanged. Its command and wrap inputs are ignored.
- R7: The queue holds DEPTH entries. req_ready is 0 exactly when DEPTH entries are held, and no request is taken while it is 0.
- R8: Accepted entries appear on the bus side in acceptance order, so a read is never issued before any write that was accepted earlier.
- R9: While bus_valid is 1 and bus_ready is 0, all bus outputs hold their values on the next cycle.
- R10: bus_addr is req_addr with its low log2(B) bits cleared.
- R11: An entry accepted into an empty queue makes bus_valid 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present from the PCI target side |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 = posted write, 0 = memory read |
| req_cmd | input | 4 | PCI command code of a read |
| req_wrap | input | 1 | Read uses cacheline wrap mode |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Write byte enables |
| rej_pulse | output | 1 | One-cycle flag for a dropped non-prefetchable read |
| bus_valid | output | 1 | Queue head is valid |
| bus_ready | input | 1 | Bus accepts the head |
| bus_write | output | 1 | Head is a write |
| bus_addr | output | ADDR_W | Beat-aligned address |
| bus_burst | output | 5 | Burst length in beats |
| bus_wdata | output | DATA_W | Write data of the head |
| bus_be | output | DATA_W/8 | Byte enables of the head |

## Verification
Every accepted request is registered into the queue at the clock edge where req_valid and req_ready are both high. An entry that lands in an empty queue is visible on the bus side one cycle later, and rej_pulse for a dropped read is also due exactly one cycle after its handshake. The bench drives and samples on the falling edge. At each falling edge it first compares the outputs, which reflect the previous rising edge, against a reference queue, and only then records the handshakes that the next rising edge will perform. A 32-bit and a 64-bit instance receive the same stimulus, so each burst value is checked for both beat sizes.

// File: rtl/pcipf_pkg.sv
package pcipf_pkg;

   localparam int BURST_W = 5;
   localparam int LINE_B  = 32;

   localparam logic [3:0] CMD_MEM_RD       = 4'b0110;
   localparam logic [3:0] CMD_MEM_RD_MULTI = 4'b1100;
   localparam logic [3:0] CMD_MEM_RD_LINE  = 4'b1110;

   typedef enum logic [2:0] {
      K_WRITE    = 3'd0,
      K_RD_WRAP  = 3'd1,
      K_RD_LINE  = 3'd2,
      K_RD_MULTI = 3'd3,
      K_BAD      = 3'd4
   } rd_kind_e;

endpackage

// File: rtl/pcipf_cmd_decode.sv
module pcipf_cmd_decode
   import pcipf_pkg::*;
(
   input  logic       is_write,
   input  logic [3:0] cmd,
   input  logic       wrap,
   output rd_kind_e   kind
);

   logic prefetch_rd;

   always_comb begin
      prefetch_rd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULTI) ||
                    (cmd == CMD_MEM_RD_LINE);
      if (is_write)
         kind = K_WRITE;
      else if (!prefetch_rd)
         kind = K_BAD;
      else if (wrap)
         kind = K_RD_WRAP;
      else if (cmd == CMD_MEM_RD_MULTI)
         kind = K_RD_MULTI;
      else
         kind = K_RD_LINE;
   end

endmodule

// File: rtl/pcipf_burst_calc.sv
module pcipf_burst_calc
   import pcipf_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  rd_kind_e             kind,
   input  logic [4:0]           addr_lo,
   output logic [BURST_W-1:0]   burst
);

   localparam int BEAT_B = DATA_W / 8;
   localparam int BPL    = LINE_B / BEAT_B;

   logic [BURST_W-1:0] idx;
   logic [BURST_W-1:0] to_next;

   generate
      if (DATA_W == 64) begin : g_beat64
         assign idx = {{(BURST_W-2){1'b0}}, addr_lo[4:3]};
      end else begin : g_beat32
         assign idx = {{(BURST_W-3){1'b0}}, addr_lo[4:2]};
      end
   endgenerate

   assign to_next = BURST_W'(BPL) - idx;

   always_comb begin
      case (kind)
         K_RD_LINE:  burst = to_next;
         K_RD_MULTI: burst = to_next + BURST_W'(BPL);
         default:    burst = BURST_W'(1);
      endcase
   end

endmodule

// File: rtl/pcipf_ord_fifo.sv
module pcipf_ord_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   localparam int PW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW:0]   wr_ptr, rd_ptr;
   logic          full, empty, push, pop;

   assign empty     = (wr_ptr == rd_ptr);
   assign full      = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
   assign in_ready  = !full;
   assign out_valid = !empty;
   assign push      = in_valid && !full;
   assign pop       = out_ready && !empty;
   assign out_data  = mem[rd_ptr[PW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr[PW-1:0]] <= in_data;
   end

endmodule

// File: rtl/pcipf_rd_sizer.sv
module pcipf_rd_sizer
   import pcipf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [3:0]          req_cmd,
   input  logic                req_wrap,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                rej_pulse,
   output logic                bus_valid,
   input  logic                bus_ready,
   output logic                bus_write,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [4:0]          bus_burst,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W/8-1:0] bus_be
);

   localparam int BE_W = DATA_W / 8;
   localparam int LG   = $clog2(BE_W);
   localparam int EW   = 1 + BURST_W + ADDR_W + DATA_W + BE_W;

   initial begin
      assert (DATA_W == 32 || DATA_W == 64)
         else $error("DATA_W must be 32 or 64");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (ADDR_W > 5)
         else $error("ADDR_W must exceed 5");
   end

   typedef struct packed {
      logic                write;
      logic [BURST_W-1:0]  burst;
      logic [ADDR_W-1:0]   addr;
      logic [DATA_W-1:0]   wdata;
      logic [BE_W-1:0]     be;
   } entry_t;

   rd_kind_e            kind;
   logic [BURST_W-1:0]  burst;
   logic [ADDR_W-1:0]   addr_al;
   entry_t              in_ent, out_ent;
   logic                q_in_valid, q_in_ready;
   logic [EW-1:0]       q_out_bits;

   pcipf_cmd_decode u_dec (
      .is_write (req_write),
      .cmd      (req_cmd),
      .wrap     (req_wrap),
      .kind     (kind)
   );

   pcipf_burst_calc #(.DATA_W(DATA_W)) u_calc (
      .kind     (kind),
      .addr_lo  (req_addr[4:0]),
      .burst    (burst)
   );

   generate
      if (LG > 0) begin : g_align
         assign addr_al = {req_addr[ADDR_W-1:LG], {LG{1'b0}}};
      end else begin : g_noalign
         assign addr_al = req_addr;
      end
   endgenerate

   always_comb begin
      in_ent.write = (kind == K_WRITE);
      in_ent.burst = burst;
      in_ent.addr  = addr_al;
      in_ent.wdata = req_wdata;
      in_ent.be    = req_be;
   end

   assign q_in_valid = req_valid && (kind != K_BAD);
   assign req_ready  = q_in_ready;

   pcipf_ord_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (q_in_valid),
      .in_ready  (q_in_ready),
      .in_data   (in_ent),
      .out_valid (bus_valid),
      .out_ready (bus_ready),
      .out_data  (q_out_bits)
   );

   assign out_ent   = entry_t'(q_out_bits);
   assign bus_write = out_ent.write;
   assign bus_addr  = out_ent.addr;
   assign bus_burst = out_ent.burst;
   assign bus_wdata = out_ent.wdata;
   assign bus_be    = out_ent.be;

   always_ff @(posedge clk) begin
      if (!rst_n) rej_pulse <= 1'b0;
      else        rej_pulse <= req_valid && req_ready && (kind == K_BAD);
   end

endmodule

// File: rtl/pcipf_rd_sizer_chk.sv
module pcipf_rd_sizer_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
)(
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic                req_write,
   input logic                rej_pulse,
   input logic                bus_valid,
   input logic                bus_ready,
   input logic                bus_write,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [4:0]          bus_burst,
   input logic [DATA_W-1:0]   bus_wdata
);

   localparam int LG  = $clog2(DATA_W / 8);
   localparam int MAXB = 2 * (32 / (DATA_W / 8));

   // R9
   hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_burst) && $stable(bus_write) && $stable(bus_wdata));

   // R10
   beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_addr[LG-1:0] == '0);

   // R4
   burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_burst >= 5'd1) && (bus_burst <= 5'(MAXB)));

   // R6
   write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write |-> bus_burst == 5'd1);

   // R5
   rej_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rej_pulse |-> $past(req_valid && req_ready && !req_write));

   // R7
   full_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> bus_valid);

endmodule

bind pcipf_rd_sizer pcipf_rd_sizer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .rej_pulse(rej_pulse), .bus_valid(bus_valid),
   .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
   .bus_burst(bus_burst), .bus_wdata(bus_wdata)
);

// File: tb/pcipf_rd_sizer_bench.sv
module pcipf_rd_sizer_bench;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wrap = 1'b0, bus_ready = 1'b0;
   logic [3:0]  req_cmd = 4'b0;
   logic [31:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [7:0]  req_be = '0;

   logic        rdy_a, rej_a, bv_a, bw_a;
   logic [31:0] ba_a;
   logic [4:0]  bb_a;
   logic [31:0] bd_a;
   logic [3:0]  be_a;
   logic        rdy_b, rej_b, bv_b, bw_b;
   logic [31:0] ba_b;
   logic [4:0]  bb_b;
   logic [63:0] bd_b;
   logic [7:0]  be_b;

   always #10 clk = ~clk;

   pcipf_rd_sizer #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) u_pcipf_rd_sizer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
      .req_write(req_write), .req_cmd(req_cmd), .req_wrap(req_wrap),
      .req_addr(req_addr), .req_wdata(req_wdata[31:0]), .req_be(req_be[3:0]),
      .rej_pulse(rej_a), .bus_valid(bv_a), .bus_ready(bus_ready),
      .bus_write(bw_a), .bus_addr(ba_a), .bus_burst(bb_a),
      .bus_wdata(bd_a), .bus_be(be_a));

   pcipf_rd_sizer #(.ADDR_W(32), .DATA_W(64), .DEPTH(DEPTH)) u_pcipf_rd_sizer_w64 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
      .req_write(req_write), .req_cmd(req_cmd), .req_wrap(req_wrap),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rej_pulse(rej_b), .bus_valid(bv_b), .bus_ready(bus_ready),
      .bus_write(bw_b), .bus_addr(ba_b), .bus_burst(bb_b),
      .bus_wdata(bd_b), .bus_be(be_b));

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // reference queue
   logic        q_w   [64];
   logic [3:0]  q_c   [64];
   logic        q_wr  [64];
   logic [31:0] q_a   [64];
   logic [63:0] q_d   [64];
   logic [7:0]  q_be  [64];
   int q_head = 0, q_cnt = 0;
   bit exp_rej = 1'b0;
   bit prev_hold = 1'b0;
   logic [31:0] p_addr;
   logic [4:0]  p_burst;
   logic        p_write;

   function automatic int exp_burst(logic w, logic [3:0] c, logic wr,
                                    logic [31:0] a, int bpb);
      int off;
      if (w || wr) return 1;
      off = int'(a[4:0]) - (int'(a[4:0]) % bpb);
      if (c == 4'b1100) return (32 - off) / bpb + 32 / bpb;
      return (32 - off) / bpb;
   endfunction

   function automatic bit is_pf(logic [3:0] c);
      return c == 4'b0110 || c == 4'b1100 || c == 4'b1110;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(bit v, bit w, logic [3:0] c, bit wr, logic [31:0] a, bit rdy);
      int k;
      @(negedge clk);
      // R11 / R8: occupancy visible one cycle after acceptance
      chk("R11 bus_valid32", bv_a, q_cnt != 0);
      chk("R11 bus_valid64", bv_b, q_cnt != 0);
      chk("R7 req_ready32", rdy_a, q_cnt < DEPTH);
      chk("R7 req_ready64", rdy_b, q_cnt < DEPTH);
      chk("R5 rej_pulse32", rej_a, exp_rej);
      chk("R5 rej_pulse64", rej_b, exp_rej);
      if (prev_hold) begin
         chk("R9 hold addr", ba_a, p_addr);
         chk("R9 hold burst", bb_a, p_burst);
         chk("R9 hold write", bw_a, p_write);
      end
      bus_ready = rdy;
      if (bv_a && rdy && q_cnt != 0) begin
         k = q_head;
         chk("R8 write flag32", bw_a, q_w[k]);
         chk("R8 write flag64", bw_b, q_w[k]);
         chk("R3 R4 R2 burst32", bb_a, exp_burst(q_w[k], q_c[k], q_wr[k], q_a[k], 4));
         chk("R3 R4 R2 burst64", bb_b, exp_burst(q_w[k], q_c[k], q_wr[k], q_a[k], 8));
         chk("R10 addr32", ba_a, q_a[k] & 32'hFFFF_FFFC);
         chk("R10 addr64", ba_b, q_a[k] & 32'hFFFF_FFF8);
         if (q_w[k]) begin
            chk("R6 wdata32", bd_a, q_d[k][31:0]);
            chk("R6 wdata64", bd_b, q_d[k]);
            chk("R6 be64", be_b, q_be[k]);
         end
         q_head = (q_head + 1) % 64;
         q_cnt--;
      end
      prev_hold = bv_a && !rdy;
      p_addr = ba_a; p_burst = bb_a; p_write = bw_a;
      req_valid = v; req_write = w; req_cmd = c; req_wrap = wr; req_addr = a;
      req_wdata = {$urandom, $urandom};
      req_be = 8'($urandom);
      exp_rej = 1'b0;
      if (v && rdy_a) begin
         if (!w && !is_pf(c)) exp_rej = 1'b1;
         else begin
            k = (q_head + q_cnt) % 64;
            q_w[k] = w; q_c[k] = c; q_wr[k] = wr; q_a[k] = a;
            q_d[k] = req_wdata; q_be[k] = req_be;
            q_cnt++;
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk("R1 valid in reset", bv_a, 0);
      chk("R1 ready in reset", rdy_a, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", bv_b, 0);
      chk("R1 rej after reset", rej_b, 0);
      // directed: R3/R4 example at 0x08, boundaries, wrap, writes, bad cmd
      step(1, 0, 4'b0110, 0, 32'h0000_1008, 1);
      step(1, 0, 4'b1100, 0, 32'h0000_1008, 1);
      step(1, 0, 4'b1110, 0, 32'h0000_201C, 1);
      step(1, 0, 4'b1100, 0, 32'h0000_2000, 1);
      step(1, 0, 4'b1100, 1, 32'h0000_2010, 1);
      step(1, 0, 4'b0010, 0, 32'h0000_3000, 1);
      step(1, 1, 4'b0111, 1, 32'h0000_3004, 1);
      step(0, 0, 4'b0, 0, 32'h0, 1);
      // R7 fill with bus stalled, then a write-before-read order check (R8)
      for (int i = 0; i < DEPTH + 3; i++)
         step(1, i[0], 4'b1110, 0, 32'h0000_4000 + 32'(i * 12), 0);
      for (int i = 0; i < DEPTH + 2; i++)
         step(0, 0, 4'b0, 0, 32'h0, 1);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] c;
         int sel = $urandom_range(0, 9);
         c = (sel < 3) ? 4'b0110 : (sel < 6) ? 4'b1100 : (sel < 9) ? 4'b1110 : 4'($urandom);
         step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 4, c,
              $urandom_range(0, 4) == 0, $urandom, $urandom_range(0, 9) < 6);
      end
      for (int i = 0; i < DEPTH + 3; i++)
         step(0, 0, 4'b0, 0, 32'h0, 1);
      chk("R8 queue drained", q_cnt, 0);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule